// File: doc/BRIEF.md
# Indirect Nibble-Port Cartridge Mapper

This block sits on the cartridge side of an 8-bit CPU bus. The lower 16 KiB of the CPU address space always map to the first ROM bank. The next 16 KiB map to a ROM bank chosen by a 5-bit bank number. The number of banks is a parameter, and the bank number is masked to it. The ROM address output is registered one clock after the CPU address.

All other state is reached indirectly through two byte locations. A write to `0xA001` selects an index. A write to `0xA000` is then routed by that index:

- It can load half of the bank number.
- It can latch a 4-bit value or an address nibble.
- It can launch a command that moves a byte between the two value nibbles and a 32-byte save RAM.
- It can launch a command that reads or writes the minute and hour digit registers of an external clock block, or that fetches its seconds count.

The results of read commands land in two return nibbles. The CPU reads those back, together with a ready status, at any address from `0x8000` up.

Top module: `nib_cart_mapper`

## Requirements
- R1: After reset the bank number, the index, the return nibbles and `cpu_rdata` are zero, and `clk_wr_en` is low.
- R2: A CPU address below `0x4000` gives a `rom_addr` equal to its low 14 bits, with every upper bit zero, one clock later.
- R3: A CPU address from `0x4000` to `0x7FFF` gives `rom_addr = bank * 0x4000 + addr[13:0]` one clock later.
- R4: A data-port write under index 0 replaces bank bits [3:0] with `data[3:0]`. A data-port write under index 1 replaces bank bit 4 with `data[0]`. The other bank bits keep their value.
- R5: The bank number used for `rom_addr` is the stored bank ANDed with `ROM_BANKS-1`, where `ROM_BANKS` is a power of two no larger than 32.
- R6: Index 4 latches the low value nibble, index 5 latches the high value nibble, and index 7 latches address bits [3:0]. A write under index 6 takes address bit 4 from `data[0]` and a command from `data[3:1]`. Command 0 stores `{high, low}` at the 5-bit address. Command 1 loads that byte into the return nibbles, high half to high and low half to low.
- R7: Command 2 with address nibble 3 returns the minute tens and ones digits (high, low). With address nibble 6 it returns the hour tens and ones digits. With any other address nibble it returns 1 in both nibbles.
- R8: Command 3 with address nibble 3 or 6 raises `clk_wr_en` for exactly one clock, in the clock after the write. `clk_wr_hour` is 0 for minutes and 1 for hours, with the high value nibble on `clk_wr_tens` and the low one on `clk_wr_ones`. Any other address nibble raises no strobe.
- R9: Command 4 puts `clk_sec` into the low return nibble and leaves the high return nibble unchanged.
- R10: A read at `0x8000` or above returns 1 under index `0x0A`, the low return nibble under `0x0C`, the high return nibble under `0x0D`, and 0 under any other index.
- R11: The return nibbles change only through commands 1, 2 and 4. The following have no effect on the return nibbles or on the bank: commands 0, 3, 5, 6 and 7, data writes under indexes 2, 3 or 8 and above, and writes to any address other than `0xA000` or `0xA001`.
- R12: `cpu_rdata` is registered. It updates only in a clock where `cpu_rd` is high and `cpu_addr` is `0x8000` or above, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one clock per write |
| cpu_rd | input | 1 | Read strobe |
| cpu_rdata | output | 8 | Registered read data for the port region |
| rom_addr | output | 14+log2(ROM_BANKS) | Registered ROM byte address |
| clk_min_tens | input | 4 | Clock block minute tens digit |
| clk_min_ones | input | 4 | Clock block minute ones digit |
| clk_hour_tens | input | 4 | Clock block hour tens digit |
| clk_hour_ones | input | 4 | Clock block hour ones digit |
| clk_sec | input | 4 | Clock block seconds count nibble |
| clk_wr_en | output | 1 | One-clock digit write strobe |
| clk_wr_hour | output | 1 | Strobe target: 0 minutes, 1 hours |
| clk_wr_tens | output | 4 | Tens digit to write |
| clk_wr_ones | output | 4 | Ones digit to write |

## Verification
The assertions check four things on every clock:
- the fixed-region mapping of `rom_addr`;
- that a clock-write strobe only follows a data-port write;
- that `cpu_rdata` holds outside port reads and its upper nibble stays zero;
- that the return nibbles stay put unless a data-port write or a pending RAM read could have moved them.

Only the bench scenarios can show the rest. That covers the exact bank composition and its masking, the RAM round trip at chosen 5-bit addresses, the digit selection of clock reads and writes, the seconds fetch leaving the high nibble alone, and the decode of each read index.

// File: rtl/nib_cart_pkg.sv
package nib_cart_pkg;
  localparam logic [15:0] PORT_DATA_ADDR  = 16'hA000;
  localparam logic [15:0] PORT_INDEX_ADDR = 16'hA001;

  localparam logic [7:0] IX_BANK_LO = 8'h00;
  localparam logic [7:0] IX_BANK_HI = 8'h01;
  localparam logic [7:0] IX_VAL_LO  = 8'h04;
  localparam logic [7:0] IX_VAL_HI  = 8'h05;
  localparam logic [7:0] IX_COMMAND = 8'h06;
  localparam logic [7:0] IX_ADDR_LO = 8'h07;
  localparam logic [7:0] IX_READY   = 8'h0A;
  localparam logic [7:0] IX_RET_LO  = 8'h0C;
  localparam logic [7:0] IX_RET_HI  = 8'h0D;

  localparam logic [3:0] SEL_MINUTES = 4'd3;
  localparam logic [3:0] SEL_HOURS   = 4'd6;

  typedef enum logic [2:0] {
    OP_RAM_STORE = 3'd0,
    OP_RAM_FETCH = 3'd1,
    OP_CLK_FETCH = 3'd2,
    OP_CLK_STORE = 3'd3,
    OP_SEC_FETCH = 3'd4
  } port_op_e;
endpackage

// File: rtl/nib_cart_bank_map.sv
module nib_cart_bank_map #(
  parameter int ROM_BANKS = 32,
  localparam int BANK_W = (ROM_BANKS > 1) ? $clog2(ROM_BANKS) : 1,
  localparam int ROM_AW = 14 + BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [3:0]        ld_data,
  output logic [ROM_AW-1:0] rom_addr
);
  localparam logic [4:0] BANK_MASK = 5'(ROM_BANKS - 1);

  logic [4:0] bank_q;
  logic [4:0] bank_sel;

  assign bank_sel = bank_q & BANK_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q   <= '0;
      rom_addr <= '0;
    end else begin
      if (ld_lo) bank_q[3:0] <= ld_data;
      if (ld_hi) bank_q[4]   <= ld_data[0];
      if (!cpu_addr[15]) begin
        if (cpu_addr[14]) rom_addr <= ROM_AW'({bank_sel, cpu_addr[13:0]});
        else              rom_addr <= ROM_AW'(cpu_addr[13:0]);
      end
    end
  end
endmodule

// File: rtl/nib_cart_save_ram.sv
module nib_cart_save_ram #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic             re,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wd,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    if (re) q <= mem[addr];
  end
endmodule

// File: rtl/nib_cart_port.sv
module nib_cart_port
  import nib_cart_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  input  logic        cpu_wr,
  input  logic        cpu_rd,
  output logic [7:0]  cpu_rdata,
  output logic        bank_ld_lo,
  output logic        bank_ld_hi,
  output logic        ram_we,
  output logic        ram_re,
  output logic [4:0]  ram_addr,
  output logic [7:0]  ram_wd,
  input  logic [7:0]  ram_q,
  input  logic [3:0]  clk_min_tens,
  input  logic [3:0]  clk_min_ones,
  input  logic [3:0]  clk_hour_tens,
  input  logic [3:0]  clk_hour_ones,
  input  logic [3:0]  clk_sec,
  output logic        clk_wr_en,
  output logic        clk_wr_hour,
  output logic [3:0]  clk_wr_tens,
  output logic [3:0]  clk_wr_ones,
  output logic [7:0]  idx_q,
  output logic [3:0]  ret_hi,
  output logic [3:0]  ret_lo,
  output logic        rd_pend
);
  logic [3:0] val_lo_q, val_hi_q, addr_lo_q;
  logic       idx_wr, dat_wr, cmd_wr;
  port_op_e   op;
  logic       sel_min, sel_hour;

  assign idx_wr   = cpu_wr && (cpu_addr == PORT_INDEX_ADDR);
  assign dat_wr   = cpu_wr && (cpu_addr == PORT_DATA_ADDR);
  assign cmd_wr   = dat_wr && (idx_q == IX_COMMAND);
  assign op       = port_op_e'(cpu_wdata[3:1]);
  assign sel_min  = (addr_lo_q == SEL_MINUTES);
  assign sel_hour = (addr_lo_q == SEL_HOURS);

  assign bank_ld_lo = dat_wr && (idx_q == IX_BANK_LO);
  assign bank_ld_hi = dat_wr && (idx_q == IX_BANK_HI);
  assign ram_addr   = {cpu_wdata[0], addr_lo_q};
  assign ram_wd     = {val_hi_q, val_lo_q};
  assign ram_we     = cmd_wr && (op == OP_RAM_STORE);
  assign ram_re     = cmd_wr && (op == OP_RAM_FETCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q       <= '0;
      val_lo_q    <= '0;
      val_hi_q    <= '0;
      addr_lo_q   <= '0;
      ret_hi      <= '0;
      ret_lo      <= '0;
      rd_pend     <= 1'b0;
      clk_wr_en   <= 1'b0;
      clk_wr_hour <= 1'b0;
      clk_wr_tens <= '0;
      clk_wr_ones <= '0;
      cpu_rdata   <= '0;
    end else begin
      rd_pend   <= ram_re;
      clk_wr_en <= 1'b0;
      if (rd_pend) begin
        ret_hi <= ram_q[7:4];
        ret_lo <= ram_q[3:0];
      end
      if (idx_wr) idx_q <= cpu_wdata;
      if (dat_wr) begin
        case (idx_q)
          IX_VAL_LO:  val_lo_q  <= cpu_wdata[3:0];
          IX_VAL_HI:  val_hi_q  <= cpu_wdata[3:0];
          IX_ADDR_LO: addr_lo_q <= cpu_wdata[3:0];
          default: ;
        endcase
      end
      if (cmd_wr) begin
        case (op)
          OP_CLK_FETCH: begin
            if (sel_min) begin
              ret_hi <= clk_min_tens;
              ret_lo <= clk_min_ones;
            end else if (sel_hour) begin
              ret_hi <= clk_hour_tens;
              ret_lo <= clk_hour_ones;
            end else begin
              ret_hi <= 4'd1;
              ret_lo <= 4'd1;
            end
          end
          OP_CLK_STORE: begin
            if (sel_min || sel_hour) begin
              clk_wr_en   <= 1'b1;
              clk_wr_hour <= sel_hour;
              clk_wr_tens <= val_hi_q;
              clk_wr_ones <= val_lo_q;
            end
          end
          OP_SEC_FETCH: ret_lo <= clk_sec;
          default: ;
        endcase
      end
      if (cpu_rd && cpu_addr[15]) begin
        case (idx_q)
          IX_READY:  cpu_rdata <= 8'd1;
          IX_RET_LO: cpu_rdata <= {4'h0, ret_lo};
          IX_RET_HI: cpu_rdata <= {4'h0, ret_hi};
          default:   cpu_rdata <= 8'd0;
        endcase
      end
    end
  end
endmodule

// File: rtl/nib_cart_mapper.sv
module nib_cart_mapper #(
  parameter int ROM_BANKS = 32,
  parameter int RAM_BYTES = 32,
  localparam int BANK_W = (ROM_BANKS > 1) ? $clog2(ROM_BANKS) : 1,
  localparam int ROM_AW = 14 + BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  output logic [7:0]        cpu_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [3:0]        clk_min_tens,
  input  logic [3:0]        clk_min_ones,
  input  logic [3:0]        clk_hour_tens,
  input  logic [3:0]        clk_hour_ones,
  input  logic [3:0]        clk_sec,
  output logic              clk_wr_en,
  output logic              clk_wr_hour,
  output logic [3:0]        clk_wr_tens,
  output logic [3:0]        clk_wr_ones
);
  logic       bank_ld_lo, bank_ld_hi;
  logic       ram_we, ram_re;
  logic [4:0] ram_addr;
  logic [7:0] ram_wd, ram_q;
  logic [7:0] idx_q;
  logic [3:0] ret_hi, ret_lo;
  logic       rd_pend;

  nib_cart_bank_map #(.ROM_BANKS(ROM_BANKS)) u_bank (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr),
    .ld_lo(bank_ld_lo), .ld_hi(bank_ld_hi), .ld_data(cpu_wdata[3:0]),
    .rom_addr(rom_addr)
  );

  nib_cart_save_ram #(.DEPTH(RAM_BYTES), .WIDTH(8)) u_ram (
    .clk(clk), .we(ram_we), .re(ram_re), .addr(ram_addr[$clog2(RAM_BYTES)-1:0]),
    .wd(ram_wd), .q(ram_q)
  );

  nib_cart_port u_port (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
    .bank_ld_lo(bank_ld_lo), .bank_ld_hi(bank_ld_hi),
    .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr), .ram_wd(ram_wd),
    .ram_q(ram_q),
    .clk_min_tens(clk_min_tens), .clk_min_ones(clk_min_ones),
    .clk_hour_tens(clk_hour_tens), .clk_hour_ones(clk_hour_ones),
    .clk_sec(clk_sec),
    .clk_wr_en(clk_wr_en), .clk_wr_hour(clk_wr_hour),
    .clk_wr_tens(clk_wr_tens), .clk_wr_ones(clk_wr_ones),
    .idx_q(idx_q), .ret_hi(ret_hi), .ret_lo(ret_lo), .rd_pend(rd_pend)
  );
endmodule

// File: rtl/nib_cart_mapper_chk.sv
module nib_cart_mapper_chk #(
  parameter int ROM_AW = 19
) (
  input logic              clk,
  input logic              rst,
  input logic [15:0]       cpu_addr,
  input logic              cpu_wr,
  input logic              cpu_rd,
  input logic [7:0]        cpu_rdata,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              clk_wr_en,
  input logic [3:0]        ret_hi,
  input logic [3:0]        ret_lo,
  input logic              rd_pend
);
  a_r2_fixed_region: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[15:14] == 2'b00) |=> (rom_addr == ROM_AW'($past(cpu_addr[13:0]))));

  a_r8_strobe_cause: assert property (@(posedge clk) disable iff (rst)
    clk_wr_en |-> $past(cpu_wr && (cpu_addr == 16'hA000)));

  a_r10_upper_zero: assert property (@(posedge clk) disable iff (rst)
    cpu_rdata[7:4] == 4'h0);

  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !(cpu_rd && cpu_addr[15]) |=> $stable(cpu_rdata));

  a_r11_ret_hold: assert property (@(posedge clk) disable iff (rst)
    (!(cpu_wr && (cpu_addr == 16'hA000)) && !rd_pend) |=> ($stable(ret_hi) && $stable(ret_lo)));
endmodule

bind nib_cart_mapper nib_cart_mapper_chk #(.ROM_AW(ROM_AW)) i_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
  .cpu_rdata(cpu_rdata), .rom_addr(rom_addr), .clk_wr_en(clk_wr_en),
  .ret_hi(ret_hi), .ret_lo(ret_lo), .rd_pend(rd_pend)
);

// File: tb/test_nib_cart_mapper.sv
`timescale 1ns/1ps
module test_nib_cart_mapper;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic [7:0]  cpu_rdata;
  logic [18:0] rom_addr;
  logic [16:0] rom_addr_s;
  logic [7:0]  rdata_s;
  logic [3:0]  min_t = 4'd4, min_o = 4'd7, hr_t = 4'd2, hr_o = 4'd1, sec = 4'hB;
  logic        wr_en, wr_hour, wr_en_s, wr_hour_s;
  logic [3:0]  wr_tens, wr_ones, wr_tens_s, wr_ones_s;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nib_cart_mapper i_nib_cart_mapper (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .rom_addr(rom_addr),
    .clk_min_tens(min_t), .clk_min_ones(min_o), .clk_hour_tens(hr_t),
    .clk_hour_ones(hr_o), .clk_sec(sec), .clk_wr_en(wr_en), .clk_wr_hour(wr_hour),
    .clk_wr_tens(wr_tens), .clk_wr_ones(wr_ones)
  );

  nib_cart_mapper #(.ROM_BANKS(8)) i_nib_cart_mapper_small (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(rdata_s), .rom_addr(rom_addr_s),
    .clk_min_tens(min_t), .clk_min_ones(min_o), .clk_hour_tens(hr_t),
    .clk_hour_ones(hr_o), .clk_sec(sec), .clk_wr_en(wr_en_s), .clk_wr_hour(wr_hour_s),
    .clk_wr_tens(wr_tens_s), .clk_wr_ones(wr_ones_s)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_addr = 16'h0000;
  endtask

  task automatic port_rd(input logic [7:0] ix, output logic [7:0] v);
    wr(16'hA001, ix);
    cpu_addr = 16'h8000; cpu_rd = 1'b1;
    @(negedge clk);
    v = cpu_rdata; cpu_rd = 1'b0; cpu_addr = 16'h0000;
  endtask

  task automatic rom_at(input logic [15:0] a);
    cpu_addr = a; cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic sel(input logic [7:0] ix, input logic [7:0] d);
    wr(16'hA001, ix);
    wr(16'hA000, d);
  endtask

  task automatic ret_pair(output logic [3:0] h, output logic [3:0] l);
    logic [7:0] v;
    port_rd(8'h0D, v); h = v[3:0];
    port_rd(8'h0C, v); l = v[3:0];
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 rdata", 32'(cpu_rdata), 0);
    check("R1 strobe", 32'(wr_en), 0);
    rom_at(16'h4000);
    check("R1 bank zero", 32'(rom_addr), 0);
    port_rd(8'h0C, v);
    check("R1 ret lo", 32'(v), 0);
  endtask

  task automatic t_banks();
    sel(8'h00, 8'hF5);
    sel(8'h01, 8'h01);
    rom_at(16'h4123);
    check("R3 bank 0x15", 32'(rom_addr), 32'h54123);
    check("R5 masked to 8", 32'(rom_addr_s), 32'h14123);
    sel(8'h00, 8'h0A);
    rom_at(16'h7FFF);
    check("R4 low nibble only", 32'(rom_addr), 32'h6BFFF);
    check("R5 masked 0x1A", 32'(rom_addr_s), 32'h0BFFF);
    rom_at(16'h3ABC);
    check("R2 fixed region", 32'(rom_addr), 32'h03ABC);
  endtask

  task automatic ram_store(input logic [4:0] a, input logic [7:0] d);
    sel(8'h07, {4'h0, a[3:0]});
    sel(8'h04, {4'h0, d[3:0]});
    sel(8'h05, {4'h0, d[7:4]});
    sel(8'h06, {4'h0, 3'd0, a[4]});
  endtask

  task automatic ram_fetch(input logic [4:0] a);
    sel(8'h07, {4'h0, a[3:0]});
    sel(8'h06, {4'h0, 3'd1, a[4]});
  endtask

  task automatic t_ram();
    logic [3:0] h, l;
    ram_store(5'h13, 8'hA5);
    ram_store(5'h03, 8'h3C);
    ram_store(5'h1F, 8'h96);
    ram_fetch(5'h13); ret_pair(h, l);
    check("R6 ram 0x13", 32'({h, l}), 32'hA5);
    ram_fetch(5'h03); ret_pair(h, l);
    check("R6 ram 0x03", 32'({h, l}), 32'h3C);
    ram_fetch(5'h1F); ret_pair(h, l);
    check("R6 ram 0x1F", 32'({h, l}), 32'h96);
  endtask

  task automatic t_clock_rd();
    logic [3:0] h, l;
    sel(8'h07, 8'h03); sel(8'h06, 8'h04); ret_pair(h, l);
    check("R7 minutes", 32'({h, l}), 32'h47);
    sel(8'h07, 8'h06); sel(8'h06, 8'h04); ret_pair(h, l);
    check("R7 hours", 32'({h, l}), 32'h21);
    min_t = 4'd0; min_o = 4'd0;
    sel(8'h07, 8'h05); sel(8'h06, 8'h04); ret_pair(h, l);
    check("R7 other addr", 32'({h, l}), 32'h11);
  endtask

  task automatic t_clock_wr();
    sel(8'h04, 8'h09);
    sel(8'h05, 8'h05);
    sel(8'h07, 8'h03);
    sel(8'h06, 8'h06);
    check("R8 strobe min", 32'({wr_en, wr_hour, wr_tens, wr_ones}), 32'h259);
    @(negedge clk);
    check("R8 one clock", 32'(wr_en), 0);
    sel(8'h07, 8'h06);
    sel(8'h06, 8'h06);
    check("R8 strobe hour", 32'({wr_en, wr_hour, wr_tens, wr_ones}), 32'h359);
    sel(8'h07, 8'h04);
    sel(8'h06, 8'h06);
    check("R8 no strobe", 32'(wr_en), 0);
  endtask

  task automatic t_seconds();
    logic [3:0] h, l;
    sel(8'h07, 8'h05); sel(8'h06, 8'h04);
    sel(8'h06, 8'h08); ret_pair(h, l);
    check("R9 seconds", 32'({h, l}), 32'h1B);
  endtask

  task automatic t_read_port();
    logic [7:0] v;
    port_rd(8'h0A, v); check("R10 ready", 32'(v), 1);
    port_rd(8'h0B, v); check("R10 idx 0B", 32'(v), 0);
    port_rd(8'hFF, v); check("R10 idx FF", 32'(v), 0);
    port_rd(8'h04, v); check("R10 idx 04", 32'(v), 0);
  endtask

  task automatic t_ignored();
    logic [3:0] h, l;
    sel(8'h06, 8'h00);
    sel(8'h06, 8'h06);
    sel(8'h06, 8'h0A);
    sel(8'h06, 8'h0E);
    sel(8'h02, 8'h0F);
    sel(8'h03, 8'h0F);
    sel(8'h08, 8'h0F);
    wr(16'h2000, 8'h0F);
    wr(16'hA002, 8'h0F);
    ret_pair(h, l);
    check("R11 ret unchanged", 32'({h, l}), 32'h1B);
    rom_at(16'h4000);
    check("R11 bank unchanged", 32'(rom_addr), 32'h68000);
  endtask

  task automatic t_hold();
    logic [7:0] v;
    port_rd(8'h0C, v);
    check("R12 read lo", 32'(v), 32'hB);
    wr(16'hA001, 8'h0A);
    check("R12 hold no rd", 32'(cpu_rdata), 32'hB);
    rom_at(16'h4000);
    check("R12 hold low rd", 32'(cpu_rdata), 32'hB);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_banks();
    t_ram();
    t_clock_rd();
    t_clock_wr();
    t_seconds();
    t_read_port();
    t_ignored();
    t_hold();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule